// File: doc/BRIEF.md
# Reflected CRC Step Unit

This unit moves a reflected CRC-32 or CRC-32C remainder forward by a chosen number of message bits. The caller has already combined the message chunk with the running remainder in a 64-bit value. It presents that value with a one-cycle start strobe, a polynomial choice and a chunk-size choice. The unit then runs the bit-serial reflected CRC recurrence for 8, 16, 32 or 64 steps.

Each step shifts the whole 64-bit state right by one bit. If the bit that falls out was a one, the selected polynomial is XORed into the low 32 bits of the state. No feedback ever reaches bits 63..32. They only move down toward the low half, so the full doubleword size folds all 64 input bits into the remainder.

An unrolled round performs several steps in each clock, eight by default. The doubleword case therefore takes eight cycles after the start is accepted. When the last round is done the unit raises done for one cycle. The result stays on its output until the next accepted start. Pre-inversion and post-inversion of the CRC are left to the caller.

Top module: `crc_step_unit`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: One step maps state x to (x >> 1) XOR ({32'h0, P} if old x[0] is 1, else 0), on the full 64-bit state. Bits 63..32 receive no feedback.
- R3: poly_sel = 0 selects P = 0xEDB88320 (CRC-32). poly_sel = 1 selects P = 0x82F63B78 (CRC-32C).
- R4: size_sel 0, 1, 2 and 3 apply 8, 16, 32 and 64 steps respectively.
- R5: A start sampled at a rising edge while the unit is idle is accepted. done rises at the rising edge that comes steps/8 edges later, and result then holds the final state.
- R6: done is high for exactly one cycle per accepted operation.
- R7: start is ignored while an operation is in progress, up to and including the edge at which done rises. Neither the result nor the completion time of the running operation changes.
- R8: result keeps its value from the done cycle until the next accepted start.
- R9: With poly_sel = 0 and size_sel = 0, the input 0x00000000FFFFFFFF gives the result 0x000000002DFD1072.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation on din |
| din | input | 64 | State value, already combined with the message chunk |
| poly_sel | input | 1 | 0: CRC-32 polynomial, 1: CRC-32C polynomial |
| size_sel | input | 2 | 0: 8, 1: 16, 2: 32, 3: 64 steps |
| result | output | 64 | State after the requested steps |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all 256 low-byte values for both polynomials at byte size. It also runs walking-one, all-ones and pseudo-random values at every size, and compares each result with a bit-serial model. Walking ones in the upper half catch a design that feeds the polynomial into bits 63..32, or that drops those bits instead of shifting them down. Checking the edge count to done at every size exposes a step count that is off by one round. It also exposes a size decode that is swapped. The bench holds start high for the whole of a long operation. A unit that re-accepted it would restart the operation, return the wrong value, or finish late. A pulse that lasts too long or a result that drifts after done is caught by sampling in the cycles that follow.

// File: rtl/crc_step_pkg.sv
package crc_step_pkg;

  localparam logic [31:0] POLY_CRC32  = 32'hEDB88320;
  localparam logic [31:0] POLY_CRC32C = 32'h82F63B78;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } chunk_size_e;

  // Number of single-bit steps for a chunk size.
  function automatic int unsigned steps_for_size(chunk_size_e sz);
    return 8 << sz;
  endfunction

  // Polynomial for the selector.
  function automatic logic [31:0] poly_for_sel(logic sel);
    return sel ? POLY_CRC32C : POLY_CRC32;
  endfunction

endpackage

// File: rtl/crc_round.sv
// Combinational unrolled chain of STEPS reflected CRC steps.
module crc_round #(
  parameter int DATA_W = 64,
  parameter int POLY_W = 32,
  parameter int STEPS  = 8
) (
  input  logic [DATA_W-1:0] state_in,
  input  logic [POLY_W-1:0] poly,
  output logic [DATA_W-1:0] state_out
);

  localparam int PAD_W = DATA_W - POLY_W;

  logic [DATA_W-1:0] chain [STEPS+1];

  assign chain[0] = state_in;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic              drop_bit;
    logic [DATA_W-1:0] fb;
    assign drop_bit     = chain[g][0];
    assign fb           = {{PAD_W{1'b0}}, poly & {POLY_W{drop_bit}}};
    assign chain[g+1]   = (chain[g] >> 1) ^ fb;
  end

  assign state_out = chain[STEPS];

endmodule

// File: rtl/crc_ctrl.sv
// Round counter: accepts start when idle, counts rounds, pulses done.
module crc_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rounds,
  output logic             load,
  output logic             advance,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_round;

  assign load       = start & ~busy_q;
  assign advance    = busy_q;
  assign last_round = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= rounds;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_round) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/crc_step_unit.sv
module crc_step_unit #(
  parameter int DATA_W          = 64,
  parameter int POLY_W          = 32,
  parameter int STEPS_PER_CYCLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              poly_sel,
  input  logic [1:0]        size_sel,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  import crc_step_pkg::*;

  localparam int MAX_ROUNDS = 64 / STEPS_PER_CYCLE;
  localparam int CNT_W      = $clog2(MAX_ROUNDS + 1);

  logic [DATA_W-1:0] state_q;
  logic [POLY_W-1:0] poly_q;
  logic [DATA_W-1:0] round_out;
  logic [CNT_W-1:0]  rounds_w;
  logic              load_w;
  logic              advance_w;
  logic              busy_w;
  logic [CNT_W-1:0]  cnt_w;

  assign rounds_w = CNT_W'(steps_for_size(chunk_size_e'(size_sel)) / STEPS_PER_CYCLE);

  crc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rounds  (rounds_w),
    .load    (load_w),
    .advance (advance_w),
    .busy    (busy_w),
    .done    (done),
    .cnt     (cnt_w)
  );

  crc_round #(
    .DATA_W (DATA_W),
    .POLY_W (POLY_W),
    .STEPS  (STEPS_PER_CYCLE)
  ) u_round (
    .state_in  (state_q),
    .poly      (poly_q),
    .state_out (round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      poly_q  <= '0;
    end else if (load_w) begin
      state_q <= din;
      poly_q  <= POLY_W'(poly_for_sel(poly_sel));
    end else if (advance_w) begin
      state_q <= round_out;
    end
  end

  assign result = state_q;

endmodule

// File: rtl/crc_step_unit_chk.sv
module crc_step_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              busy,
  input logic              load,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] result
);

  // R6: completion pulse lasts one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: leaving busy coincides with done
  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5: an accepted start makes the unit busy
  assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R7: a start during a running operation does not reload the counter
  assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt > CNT_W'(1)) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

  // R8: idle with no start keeps the result
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

endmodule

bind crc_step_unit crc_step_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .done   (done),
  .busy   (busy_w),
  .load   (load_w),
  .cnt    (cnt_w),
  .result (result)
);

// File: tb/crc_step_unit_test.sv
module crc_step_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] din = '0;
  logic        poly_sel = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic [63:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] lcg = 64'h0123_4567_89AB_CDEF;

  always #5 clk = ~clk;

  crc_step_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .poly_sel(poly_sel), .size_sel(size_sel), .result(result), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Bit-serial reference written from R2/R3/R4
  function automatic logic [63:0] ref_crc(logic [63:0] v, logic psel, int nsteps);
    logic [63:0] p;
    p = psel ? 64'h0000_0000_82F6_3B78 : 64'h0000_0000_EDB8_8320;
    for (int i = 0; i < nsteps; i++) begin
      if (v[0]) v = (v >> 1) ^ p;
      else      v = v >> 1;
    end
    return v;
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start one operation; start held through busy when hold_start is set.
  task automatic run_op(logic [63:0] v, logic psel, logic [1:0] sz, bit hold_start);
    int n;
    int edges;
    logic [63:0] exp;
    logic [63:0] got;
    n   = (8 << sz) / 8;
    exp = ref_crc(v, psel, 8 << sz);
    @(negedge clk);
    din = v; poly_sel = psel; size_sel = sz; start = 1'b1;
    @(posedge clk);
    edges = 0;
    @(negedge clk);
    if (hold_start) begin
      din = ~v; poly_sel = ~psel; size_sel = 2'd0;
    end else begin
      start = 1'b0;
    end
    while (done !== 1'b1 && edges < 20) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    start = 1'b0;
    // R5 timing and R4 step count via edge count
    checks++;
    if (edges != n) begin
      errors++;
      $display("FAIL R5: done after %0d edges, expected %0d", edges, n);
    end
    got = result;
    check64(hold_start ? "R7" : "R2/R3/R4", got, exp);
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R6: done=%b expected 0", done);
    end
    @(negedge clk);
    check64("R8", result, got);
  endtask

  initial begin
    #1;
    checks++;
    if (done !== 1'b0 || result !== 64'h0) begin
      errors++;
      $display("FAIL R1: done=%b result=%h expected 0 and 0", done, result);
    end
    #22 rst_n = 1'b1;

    // R9: known CRC-32 vector (byte 0x00 after state 0xFFFFFFFF)
    run_op(64'h0000_0000_FFFF_FFFF, 1'b0, 2'd0, 1'b0);
    check64("R9", result, 64'h0000_0000_2DFD_1072);

    // Exhaustive low-byte sweep for both polynomials (R2, R3)
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 256; b++)
        run_op({56'h00_1234_5678_9ABC, 8'(b)}, p[0], 2'd0, 1'b0);

    // Every size with structured and pseudo-random values (R4, R2 upper bits)
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++) begin
        run_op(64'h0, p[0], 2'(s), 1'b0);
        run_op(64'hFFFF_FFFF_FFFF_FFFF, p[0], 2'(s), 1'b0);
        for (int k = 0; k < 64; k += 7)
          run_op(64'h1 << k, p[0], 2'(s), 1'b0);
        for (int r = 0; r < 6; r++) begin
          lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
          run_op(lcg, p[0], 2'(s), 1'b0);
        end
      end

    // R7: start held high during whole operation, inputs changed
    run_op(64'hDEAD_BEEF_0BAD_F00D, 1'b1, 2'd3, 1'b1);
    run_op(64'h8000_0000_0000_0001, 1'b0, 2'd2, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule